// File: doc/BRIEF.md
# Column-Pair Scan Driver for a 10-Character 5x5 LED Matrix

This block keeps a ten-character LED dot-matrix display lit. Each character is a 5x5 grid of pixels. The display has no controller of its own. It is driven through an external 40-stage serial-in, parallel-out register chain that uses three wires: a data line, a shift clock and a latch strobe. The block holds a picture of 50 column entries, 5 bits each. A host fills this picture through a plain addressed write port. The scan engine then sends the picture out, one column pair at a time.

The characters form five two-character blocks. Each block has five column-drive lines. One column-drive line lights column Z of the odd character and column 6-Z of the even character next to it. The ten row lines are shared by all blocks. So each scan word selects exactly one column-drive line and carries two row patterns: one for the odd character and one for the even character of that pair. Twenty-five such words make one frame, and frames repeat with no pause. When the enable input falls, the block finishes the word it is sending. It then sends and latches an all-zero word, so that no LED is left lit, and stays quiet until enable rises again.

Top module: `dotscan_driver`

## Requirements
- R1: Each word is sent as 40 rising edges of ser_clk_o, chain bit 0 first and bit 39 last. After the 40th edge comes one ser_latch_o pulse, high for 2*HALF_PERIOD clocks while ser_clk_o is low.
- R2: ser_clk_o is low for HALF_PERIOD clocks and then high for HALF_PERIOD clocks. ser_data_o does not change in the clock before a rising edge or while ser_clk_o is high.
- R3: Chain bits 0-4 are always 0. In a display word, exactly one bit among bits 5-29 is 1, at bit base+(c-1) for block b and column c. The base is 5 for block 1 (characters 1+2), 20 for block 2 (3+4), 25 for block 3 (5+6), 10 for block 4 (7+8) and 15 for block 5 (9+10).
- R4: Bits 30-34 hold rows 1-5 of picture entry 10(b-1)+(c-1), the odd character. Bits 35-39 hold rows 1-5 of entry 10(b-1)+(10-c), the even character. In each entry, data bit r-1 is row r. Entries 10(b-1)+0..4 are odd-character columns 1-5, and entries 10(b-1)+5..9 are even-character columns 1-5.
- R5: Words follow the order block 1..5 in the outer loop and column 1..5 in the inner loop, 25 words per frame. Frames repeat with no gap while enable_i is high.
- R6: A write with wr_en_i high and wr_addr_i in 0-49 sets that entry to wr_data_i. Any word that starts after that clock uses the new value. Writes to addresses 50-63 change no entry.
- R7: When enable_i goes low, the word in flight completes. Then one all-zero word is sent and latched. After that, ser_clk_o and ser_latch_o stay low while enable_i stays low.
- R8: When enable_i goes high from the idle state, the first word sent is block 1, column 1.
- R9: frame_done_o is high for exactly one clock, in the clock after the latch pulse of each frame's 25th word ends. It never pulses for the all-zero word.
- R10: After reset, all outputs are low, every picture entry is 0, and nothing is sent while enable_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Scan enable; low parks the display blank |
| wr_en_i | input | 1 | Picture write strobe |
| wr_addr_i | input | 6 | Picture entry index, 0-49 valid |
| wr_data_i | input | 5 | Row pattern, bit r-1 = row r |
| ser_data_o | output | 1 | Serial data to the register chain |
| ser_clk_o | output | 1 | Shift clock to the register chain |
| ser_latch_o | output | 1 | Latch strobe to the register chain |
| frame_done_o | output | 1 | One-clock strobe after each full frame |

## Verification
The bench builds the driver with HALF_PERIOD set to 1. This is the shortest legal shift-clock period: one low clock and one high clock. At this setting the rule that data must be set up one clock before the rising edge has no slack at all. It also means a word takes only 83 clocks, so several complete frames fit in a short run. These include a frame with a write made partway through, a shutdown started in the middle of a word, and a restart. A model of the external register chain in the bench rebuilds every latched word, so the bit placement and the scrambled block slots are compared bit by bit.

// File: rtl/dotscan_pkg.sv
`timescale 1ns/1ps
package dotscan_pkg;

    localparam int N_BLK       = 5;
    localparam int N_COL       = 5;
    localparam int N_ROW       = 5;
    localparam int N_ENT       = N_BLK * 2 * N_COL;
    localparam int ADDR_W      = $clog2(N_ENT + 1);
    localparam int COLF_LO     = 5;
    localparam int ROW_ODD_LO  = COLF_LO + N_BLK * N_COL;
    localparam int ROW_EVEN_LO = ROW_ODD_LO + N_ROW;
    localparam int CHAIN_W     = ROW_EVEN_LO + N_ROW;
    localparam int BLK_W       = $clog2(N_BLK);
    localparam int COL_W       = $clog2(N_COL);
    localparam int BIT_W       = $clog2(CHAIN_W);

    typedef logic [N_ROW-1:0]   rows_t;
    typedef logic [CHAIN_W-1:0] word_t;

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [COL_W-1:0] col;
    } scanpos_t;

    typedef enum logic [1:0] {SEQ_OFF, SEQ_RUN, SEQ_BLANK} seqmode_t;
    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_LATCH} shst_t;

    // Field slot in the chain for each character block (wiring order).
    function automatic int slot_of_block(input int b);
        case (b)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            3:       return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int field_lo(input int b);
        return COLF_LO + slot_of_block(b) * N_COL;
    endfunction

    function automatic logic [ADDR_W-1:0] odd_entry(input scanpos_t p);
        return ADDR_W'(32'(p.blk) * (2 * N_COL) + 32'(p.col));
    endfunction

    function automatic logic [ADDR_W-1:0] even_entry(input scanpos_t p);
        return ADDR_W'(32'(p.blk) * (2 * N_COL) + (2 * N_COL - 1) - 32'(p.col));
    endfunction

    function automatic scanpos_t next_pos(input scanpos_t p);
        scanpos_t n;
        n = p;
        if (p.col == COL_W'(N_COL - 1)) begin
            n.col = '0;
            n.blk = (p.blk == BLK_W'(N_BLK - 1)) ? '0 : p.blk + 1'b1;
        end else begin
            n.col = p.col + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/dotscan_fbuf.sv
`timescale 1ns/1ps
module dotscan_fbuf
    import dotscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  rows_t             wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output rows_t             rdata_a,
    output rows_t             rdata_b
);

    logic [N_ENT-1:0][N_ROW-1:0] mem;
    logic                        wr_ok;

    assign wr_ok = we && (waddr < ADDR_W'(N_ENT));

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_ok) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R6: an out-of-range write leaves the picture untouched
    assert_oob_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr >= ADDR_W'(N_ENT))) |=> $stable(mem));

endmodule

// File: rtl/dotscan_wordgen.sv
`timescale 1ns/1ps
module dotscan_wordgen
    import dotscan_pkg::*;
(
    input  scanpos_t pos,
    input  logic     blank,
    input  rows_t    odd_rows,
    input  rows_t    even_rows,
    output word_t    word
);

    logic [N_COL-1:0] col_onehot;

    assign col_onehot = N_COL'(1) << pos.col;

    assign word[COLF_LO-1:0] = '0;

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        localparam int LO = field_lo(b);
        assign word[LO +: N_COL] =
            (!blank && (pos.blk == BLK_W'(b))) ? col_onehot : '0;
    end

    assign word[ROW_ODD_LO  +: N_ROW] = blank ? '0 : odd_rows;
    assign word[ROW_EVEN_LO +: N_ROW] = blank ? '0 : even_rows;

endmodule

// File: rtl/dotscan_shift.sv
`timescale 1ns/1ps
module dotscan_shift
    import dotscan_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t word_i,
    output logic  idle_o,
    output logic  done_o,
    output logic  sdata_o,
    output logic  sclk_o,
    output logic  slatch_o
);

    localparam int PH_W = (2 * HALF_PERIOD > 1) ? $clog2(2 * HALF_PERIOD) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * HALF_PERIOD - 1);
    localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(HALF_PERIOD);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAIN_W - 1);

    shst_t            st;
    word_t            sreg;
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SH_IDLE;
            sreg <= '0;
            ph   <= '0;
            bcnt <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        sreg <= word_i;
                        ph   <= '0;
                        bcnt <= '0;
                        st   <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (ph == PH_LAST) begin
                        ph <= '0;
                        if (bcnt == BIT_LAST) begin
                            st <= SH_LATCH;
                        end else begin
                            sreg <= sreg >> 1;
                            bcnt <= bcnt + 1'b1;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                SH_LATCH: begin
                    if (ph == PH_LAST) begin
                        ph <= '0;
                        st <= SH_IDLE;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    assign idle_o   = (st == SH_IDLE);
    assign done_o   = (st == SH_LATCH) && (ph == PH_LAST);
    assign sdata_o  = (st == SH_SHIFT) && sreg[0];
    assign sclk_o   = (st == SH_SHIFT) && (ph >= PH_RISE);
    assign slatch_o = (st == SH_LATCH);

    // R2: data settled before the rising edge and held through the high phase
    assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(sdata_o));

    // R1: the latch pulse follows a shift-clock high phase directly
    assert_latch_after_clk_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(slatch_o) |-> $past(sclk_o));

    // R1: a word is accepted only when the serializer is free
    assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        start |-> idle_o);

endmodule

// File: rtl/dotscan_driver.sv
`timescale 1ns/1ps
module dotscan_driver
    import dotscan_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [N_ROW-1:0]  wr_data_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              ser_latch_o,
    output logic              frame_done_o
);

    seqmode_t          mode_q;
    scanpos_t          pos_q;
    logic              last_q;
    logic              fdone_q;

    logic              sh_idle;
    logic              sh_done;
    logic              sh_start;
    logic              blank_sel;
    logic              pos_is_last;
    word_t             word;
    rows_t             odd_rows;
    rows_t             even_rows;
    logic [ADDR_W-1:0] ra_odd;
    logic [ADDR_W-1:0] ra_even;

    assign ra_odd      = odd_entry(pos_q);
    assign ra_even     = even_entry(pos_q);
    assign pos_is_last = (pos_q.blk == BLK_W'(N_BLK - 1)) &&
                         (pos_q.col == COL_W'(N_COL - 1));
    assign blank_sel   = (mode_q == SEQ_RUN) && !enable_i;
    assign sh_start    = sh_idle &&
                         (((mode_q == SEQ_OFF) && enable_i) || (mode_q == SEQ_RUN));

    dotscan_fbuf i_fbuf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en_i),
        .waddr   (wr_addr_i),
        .wdata   (wr_data_i),
        .raddr_a (ra_odd),
        .raddr_b (ra_even),
        .rdata_a (odd_rows),
        .rdata_b (even_rows)
    );

    dotscan_wordgen i_wordgen (
        .pos       (pos_q),
        .blank     (blank_sel),
        .odd_rows  (odd_rows),
        .even_rows (even_rows),
        .word      (word)
    );

    dotscan_shift #(.HALF_PERIOD(HALF_PERIOD)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (sh_start),
        .word_i   (word),
        .idle_o   (sh_idle),
        .done_o   (sh_done),
        .sdata_o  (ser_data_o),
        .sclk_o   (ser_clk_o),
        .slatch_o (ser_latch_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= SEQ_OFF;
            pos_q   <= '0;
            last_q  <= 1'b0;
            fdone_q <= 1'b0;
        end else begin
            fdone_q <= sh_done && last_q;
            case (mode_q)
                SEQ_OFF: begin
                    if (sh_start) begin
                        mode_q <= SEQ_RUN;
                        last_q <= pos_is_last;
                        pos_q  <= next_pos(pos_q);
                    end
                end
                SEQ_RUN: begin
                    if (sh_start) begin
                        if (blank_sel) begin
                            mode_q <= SEQ_BLANK;
                            last_q <= 1'b0;
                            pos_q  <= '0;
                        end else begin
                            last_q <= pos_is_last;
                            pos_q  <= next_pos(pos_q);
                        end
                    end
                end
                SEQ_BLANK: begin
                    if (sh_idle) begin
                        mode_q <= SEQ_OFF;
                    end
                end
                default: mode_q <= SEQ_OFF;
            endcase
        end
    end

    assign frame_done_o = fdone_q;

    // R9: the frame strobe lasts one clock
    assert_frame_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

    // R3: a display word selects one column line and leaves the low bits clear
    assert_one_column_R3: assert property (@(posedge clk) disable iff (rst)
        (sh_start && !blank_sel) |->
            (($countones(word[ROW_ODD_LO-1:COLF_LO]) == 1) && (word[COLF_LO-1:0] == '0)));

    // R7: the shutdown word carries no set bit
    assert_blank_word_R7: assert property (@(posedge clk) disable iff (rst)
        (sh_start && blank_sel) |-> (word == '0));

    // R7: nothing toggles on the chain while parked
    assert_parked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SEQ_OFF) |-> (!ser_clk_o && !ser_latch_o));

    // R8: a parked scan always resumes at the first column pair
    assert_restart_origin_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SEQ_OFF) |-> (pos_q == '0));

endmodule

// File: tb/test_dotscan_driver.sv
`timescale 1ns/1ps
module test_dotscan_driver;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable_i;
    logic       wr_en_i;
    logic [5:0] wr_addr_i;
    logic [4:0] wr_data_i;
    logic       ser_data_o;
    logic       ser_clk_o;
    logic       ser_latch_o;
    logic       frame_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dotscan_driver #(.HALF_PERIOD(1)) i_dotscan_driver (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (enable_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .ser_data_o   (ser_data_o),
        .ser_clk_o    (ser_clk_o),
        .ser_latch_o  (ser_latch_o),
        .frame_done_o (frame_done_o)
    );

    // Model of the external register chain
    logic [39:0] chain_m = '0;
    logic [39:0] lat_w [0:255];
    int          lat_sck [0:255];
    int          lat_n = 0;
    int          sck_cnt = 0;

    always @(posedge ser_clk_o) begin
        chain_m = {ser_data_o, chain_m[39:1]};
        sck_cnt = sck_cnt + 1;
    end

    always @(posedge ser_latch_o) begin
        if (lat_n < 256) begin
            lat_w[lat_n]   = chain_m;
            lat_sck[lat_n] = sck_cnt;
        end
        lat_n   = lat_n + 1;
        sck_cnt = 0;
    end

    // Timing monitor sampled mid-cycle
    logic prev_sclk = 0, prev_sdata = 0;
    int   setup_viol = 0, overlap_viol = 0, lat_run = 0, lat_bad = 0;
    int   hi_run = 0, lo_run = 0, clk_shape_bad = 0;
    int   fd_n = 0, fd_wide = 0;
    int   fd_lat [0:15];
    logic prev_fd = 0;

    always @(negedge clk) begin
        if (ser_clk_o && prev_sclk && (ser_data_o != prev_sdata)) setup_viol++;
        if (ser_clk_o && !prev_sclk && (ser_data_o != prev_sdata)) setup_viol++;
        if (ser_clk_o && ser_latch_o) overlap_viol++;
        if (ser_latch_o) lat_run++;
        else begin
            if (lat_run != 0 && lat_run != 2) lat_bad++;
            lat_run = 0;
        end
        if (ser_clk_o) begin
            hi_run++;
            if (hi_run > 1) clk_shape_bad++;
        end else hi_run = 0;
        if (frame_done_o) begin
            if (prev_fd) fd_wide++;
            else begin
                if (fd_n < 16) fd_lat[fd_n] = lat_n;
                fd_n++;
            end
        end
        prev_fd    = frame_done_o;
        prev_sclk  = ser_clk_o;
        prev_sdata = ser_data_o;
    end

    logic [4:0] mem_m [0:49];

    function automatic logic [39:0] exp_word(input int b, input int c);
        logic [39:0] w;
        int base;
        case (b)
            0: base = 5;
            1: base = 20;
            2: base = 25;
            3: base = 10;
            default: base = 15;
        endcase
        w = '0;
        w[base + c] = 1'b1;
        w[34:30] = mem_m[b*10 + c];
        w[39:35] = mem_m[b*10 + 9 - c];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_lat(input int target);
        int guard = 0;
        while (lat_n < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic host_write(input int a, input logic [4:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = 6'(a);
        wr_data_i = d;
        if (a < 50) mem_m[a] = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic stop_scan();
        int l0;
        while (sck_cnt != 10) @(negedge clk);
        enable_i = 1'b0;
        l0 = lat_n;
        wait_lat(l0 + 2);
        tick(20);
    endtask

    task automatic t_reset();
        rst = 1'b1; enable_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        for (int i = 0; i < 50; i++) mem_m[i] = '0;
        tick(4);
        rst = 1'b0;
        tick(1);
        check(!ser_clk_o && !ser_latch_o && !ser_data_o && !frame_done_o,
              "R10 outputs low after reset",
              {ser_clk_o, ser_latch_o, ser_data_o, frame_done_o}, 0);
        tick(200);
        check(lat_n == 0 && sck_cnt == 0, "R10 nothing sent while disabled",
              lat_n + sck_cnt, 0);
        // R10: cleared picture gives rows of zero in the first word
        enable_i = 1'b1;
        wait_lat(1);
        check(lat_w[0] == exp_word(0, 0), "R10 picture cleared by reset",
              lat_w[0], exp_word(0, 0));
        stop_scan();
    endtask

    task automatic t_frames();
        int base, fd0, bad_w, bad_s;
        for (int i = 0; i < 50; i++) host_write(i, 5'((i * 7 + 3) % 32));
        base = lat_n; fd0 = fd_n; bad_w = 0; bad_s = 0;
        enable_i = 1'b1;
        wait_lat(base + 50);
        for (int k = 0; k < 50; k++) begin
            int kk = k % 25;
            if (lat_w[base + k] != exp_word(kk / 5, kk % 5)) begin
                bad_w++;
                if (bad_w == 1)
                    check(0, "R3 R4 R5 word contents", lat_w[base + k],
                          exp_word(kk / 5, kk % 5));
            end
            if (lat_sck[base + k] != 40) bad_s++;
        end
        check(bad_w == 0, "R5 two frames in block-major order", bad_w, 0);
        check(lat_w[base][4:0] == 0, "R3 low chain bits clear", lat_w[base][4:0], 0);
        check(lat_w[base + 13] == exp_word(2, 3), "R4 block 3 column 4 rows",
              lat_w[base + 13], exp_word(2, 3));
        check(bad_s == 0, "R1 forty shift edges per word", bad_s, 0);
        tick(5);
        check(fd_n - fd0 >= 2, "R9 frame strobe per frame", fd_n - fd0, 2);
        check(fd_lat[fd0] == base + 25, "R9 strobe after 25th latch",
              fd_lat[fd0], base + 25);
        check(fd_lat[fd0 + 1] == base + 50, "R9 strobe after 50th latch",
              fd_lat[fd0 + 1], base + 50);
    endtask

    task automatic t_disable();
        int base, l0, k, fd0;
        base = lat_n - ((lat_n - 0) % 1);
        while (sck_cnt != 10) @(negedge clk);
        enable_i = 1'b0;
        l0 = lat_n;
        fd0 = fd_n;
        wait_lat(l0 + 2);
        tick(300);
        k = (l0 - base) % 25;
        check(lat_n == l0 + 2, "R7 exactly two latches after disable", lat_n, l0 + 2);
        check(lat_w[l0 + 1] == 0, "R7 all-zero word latched", lat_w[l0 + 1], 0);
        check(lat_w[l0][29:5] != 0 && lat_sck[l0] == 40, "R7 word in flight completed",
              lat_w[l0], k);
        check(sck_cnt == 0 && !ser_clk_o && !ser_latch_o, "R7 chain quiet while off",
              sck_cnt, 0);
        check(fd_n == fd0 || lat_w[l0] == exp_word(4, 4), "R9 no strobe for zero word",
              fd_n, fd0);
    endtask

    task automatic t_restart();
        int base;
        host_write(0, 5'h15);
        host_write(9, 5'h0A);
        host_write(7, 5'h1F);
        base = lat_n;
        enable_i = 1'b1;
        wait_lat(base + 5);
        check(lat_w[base] == exp_word(0, 0), "R8 restart at block 1 column 1",
              lat_w[base], exp_word(0, 0));
        check(lat_w[base + 2] == exp_word(0, 2), "R6 written entry shown",
              lat_w[base + 2], exp_word(0, 2));
        check(lat_w[base + 4] == exp_word(0, 4), "R5 first block columns in order",
              lat_w[base + 4], exp_word(0, 4));
        stop_scan();
    endtask

    task automatic t_live_write();
        int base;
        base = lat_n;
        enable_i = 1'b1;
        wait_lat(base + 2);
        host_write(49, 5'h11);
        host_write(33, 5'h06);
        wait_lat(base + 25);
        check(lat_w[base + 20] == exp_word(4, 0), "R6 mid-frame write to entry 49",
              lat_w[base + 20], exp_word(4, 0));
        check(lat_w[base + 18] == exp_word(3, 3), "R6 mid-frame write to entry 33",
              lat_w[base + 18], exp_word(3, 3));
        stop_scan();
    endtask

    task automatic t_oob();
        int base, bad;
        for (int a = 50; a < 64; a++) host_write(a, 5'h1F);
        base = lat_n; bad = 0;
        enable_i = 1'b1;
        wait_lat(base + 25);
        for (int k = 0; k < 25; k++)
            if (lat_w[base + k] != exp_word(k / 5, k % 5)) bad++;
        check(bad == 0, "R6 writes to 50-63 ignored", bad, 0);
        check(setup_viol == 0, "R2 data stable around rising edge", setup_viol, 0);
        check(clk_shape_bad == 0, "R2 shift clock high one clock", clk_shape_bad, 0);
        check(overlap_viol == 0 && lat_bad == 0, "R1 latch width and clock low",
              {overlap_viol[31:0], lat_bad[31:0]}, 0);
        check(fd_wide == 0, "R9 strobe one clock wide", fd_wide, 0);
        stop_scan();
    endtask

    initial begin
        t_reset();
        t_frames();
        t_disable();
        t_restart();
        t_live_write();
        t_oob();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule